// File: doc/BRIEF.md
# Ternary Ingress Packet Filter Table

This block holds a small table of ingress filter rules and classifies one packet key per cycle against all of them in parallel. Each rule stores a value and a mask for every header field it can test. A field matches when the packet field ANDed with the mask equals the stored value. A rule hits only when all of its fields match and its address-family bit equals the packet's. A field whose value and mask are both zero matches any content.

The key has two parts. The first is a compressed tuple of up to 36 bits, packed upstream under one field selection that every rule shares. The second holds fields that are always present: a 128-bit local address, a 128-bit foreign address, and the local and foreign 16-bit ports. An IPv4 address sits in the low 32 bits of its 128-bit field.

A configuration port writes a whole rule, or deletes one, at a chosen index. The lookup result comes one cycle after the key is presented. It carries the hit flag, the winning index, the dispatch action, the steering mode and the queue number. Each rule has a saturating hit counter, which can be read through a select input.

Top module: `ingress_filter_table`

## Requirements
- R1: A rule hits only when it is valid and, for every stored field, (key field AND mask) equals the stored value. This applies to the tuple, both addresses and both ports.
- R2: A field whose value and mask are both zero matches any key content in that field.
- R3: The address-family bit (0 for IPv4, 1 for IPv6) of a rule must equal the key's family bit exactly. No mask applies to it.
- R4: When several rules hit, the one with the lowest index wins, and that index is reported on resIdx.
- R5: A lookup that hits no rule reports resHit=0, resIdx=0, resAction=0 (pass), resDirect=0 and resQueue=0.
- R6: resAction reports the winning rule's 2-bit action code, where pass=0, drop=1 and switch=2. A stored code of 3 is reported as pass (0).
- R7: When the winning rule's steering bit is 1 (direct), resDirect=1 and resQueue carries its 10-bit queue number. When the bit is 0 (hash), resDirect=0 and resQueue=0.
- R8: resValid is high in exactly the cycle after lkValid was high. All result outputs are zero while resValid is low.
- R9: A delete clears the rule at cfgIdx so that it never hits afterwards. When write and delete are asserted together, the delete takes effect.
- R10: On each lookup, only the winning rule's counter increments, and only if that rule's count-enable bit is set. Counters saturate at their all-ones value and hold when nothing happens.
- R11: Reset clears every rule and every counter. A write or a delete at an index clears that index's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Write a full rule at cfgIdx |
| cfgDelete | input | 1 | Invalidate the rule at cfgIdx |
| cfgIdx | input | IDX_W | Target rule index |
| cfgValTuple | input | TUPLE_W | Compressed tuple value |
| cfgMaskTuple | input | TUPLE_W | Compressed tuple mask |
| cfgValLip | input | ADDR_W | Local address value |
| cfgMaskLip | input | ADDR_W | Local address mask |
| cfgValFip | input | ADDR_W | Foreign address value |
| cfgMaskFip | input | ADDR_W | Foreign address mask |
| cfgValLport | input | PORT_W | Local port value |
| cfgMaskLport | input | PORT_W | Local port mask |
| cfgValFport | input | PORT_W | Foreign port value |
| cfgMaskFport | input | PORT_W | Foreign port mask |
| cfgIsV6 | input | 1 | Rule address family |
| cfgAction | input | 2 | Action code |
| cfgDirect | input | 1 | 1 = direct queue, 0 = hash steering |
| cfgQueue | input | QID_W | Ingress queue number |
| cfgCountEn | input | 1 | Enable hit counting for this rule |
| lkValid | input | 1 | Key present this cycle |
| lkTuple | input | TUPLE_W | Packed compressed tuple |
| lkLip | input | ADDR_W | Local address |
| lkFip | input | ADDR_W | Foreign address |
| lkLport | input | PORT_W | Local port |
| lkFport | input | PORT_W | Foreign port |
| lkIsV6 | input | 1 | Key address family |
| resValid | output | 1 | Result valid |
| resHit | output | 1 | Some rule hit |
| resIdx | output | IDX_W | Winning rule index |
| resAction | output | 2 | Action of winner |
| resDirect | output | 1 | Steering mode of winner |
| resQueue | output | QID_W | Queue number of winner |
| cntSel | input | IDX_W | Counter read select |
| cntValue | output | CNT_W | Hit count of selected rule |

## Verification
On every cycle, the assertions check four things: the one-cycle result timing, the all-zero default result on a miss and while idle, the fact that the reserved action code never appears, and the zero queue under hash steering. They also check that a counter holds when no lookup or configuration happens. Only the bench scenarios can show the rest. That covers the per-field ternary comparison, the wildcard pairs, the exact address-family match, lowest-index priority among overlapping rules, and delete beating write. It also covers counter clearing on rewrite and saturation. These are shown by sweeping keys across overlapping rules and comparing against an arithmetic model.

// File: rtl/filt_pkg.sv
package filt_pkg;
  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_DROP   = 2'd1,
    ACT_SWITCH = 2'd2,
    ACT_RSVD   = 2'd3
  } act_e;

  typedef struct packed {
    logic load;
    logic kill;
    logic bump;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/filt_ctrl.sv
module filt_ctrl import filt_pkg::*; #(
  parameter int NUM_RULES = 8,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic                 cfgWrite,
  input  logic                 cfgDelete,
  input  logic                 lkValid,
  input  logic [NUM_RULES-1:0] matchVec,
  input  logic [NUM_RULES-1:0] countEnVec,
  output strobe_t              strb,
  output logic [IDX_W-1:0]     winIdx,
  output logic                 anyHit
);
  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  always_comb begin
    strb.kill    = cfgDelete;
    strb.load    = cfgWrite & ~cfgDelete;
    strb.capture = lkValid;
    strb.bump    = lkValid & anyHit & countEnVec[winIdx];
  end
endmodule

// File: rtl/filt_datapath.sv
module filt_datapath import filt_pkg::*; #(
  parameter int NUM_RULES = 8,
  parameter int TUPLE_W   = 36,
  parameter int ADDR_W    = 128,
  parameter int PORT_W    = 16,
  parameter int QID_W     = 10,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic [TUPLE_W-1:0]   cfgValTuple,
  input  logic [TUPLE_W-1:0]   cfgMaskTuple,
  input  logic [ADDR_W-1:0]    cfgValLip,
  input  logic [ADDR_W-1:0]    cfgMaskLip,
  input  logic [ADDR_W-1:0]    cfgValFip,
  input  logic [ADDR_W-1:0]    cfgMaskFip,
  input  logic [PORT_W-1:0]    cfgValLport,
  input  logic [PORT_W-1:0]    cfgMaskLport,
  input  logic [PORT_W-1:0]    cfgValFport,
  input  logic [PORT_W-1:0]    cfgMaskFport,
  input  logic                 cfgIsV6,
  input  logic [1:0]           cfgAction,
  input  logic                 cfgDirect,
  input  logic [QID_W-1:0]     cfgQueue,
  input  logic                 cfgCountEn,
  input  logic [TUPLE_W-1:0]   lkTuple,
  input  logic [ADDR_W-1:0]    lkLip,
  input  logic [ADDR_W-1:0]    lkFip,
  input  logic [PORT_W-1:0]    lkLport,
  input  logic [PORT_W-1:0]    lkFport,
  input  logic                 lkIsV6,
  input  logic [IDX_W-1:0]     winIdx,
  input  logic                 anyHit,
  output logic [NUM_RULES-1:0] matchVec,
  output logic [NUM_RULES-1:0] countEnVec,
  output logic                 resValid,
  output logic                 resHit,
  output logic [IDX_W-1:0]     resIdx,
  output logic [1:0]           resAction,
  output logic                 resDirect,
  output logic [QID_W-1:0]     resQueue,
  input  logic [IDX_W-1:0]     cntSel,
  output logic [CNT_W-1:0]     cntValue
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                 ruleValid [NUM_RULES];
  logic [TUPLE_W-1:0]   vTuple    [NUM_RULES];
  logic [TUPLE_W-1:0]   mTuple    [NUM_RULES];
  logic [ADDR_W-1:0]    vLip      [NUM_RULES];
  logic [ADDR_W-1:0]    mLip      [NUM_RULES];
  logic [ADDR_W-1:0]    vFip      [NUM_RULES];
  logic [ADDR_W-1:0]    mFip      [NUM_RULES];
  logic [PORT_W-1:0]    vLport    [NUM_RULES];
  logic [PORT_W-1:0]    mLport    [NUM_RULES];
  logic [PORT_W-1:0]    vFport    [NUM_RULES];
  logic [PORT_W-1:0]    mFport    [NUM_RULES];
  logic                 ruleV6    [NUM_RULES];
  logic [1:0]           ruleAct   [NUM_RULES];
  logic                 ruleDir   [NUM_RULES];
  logic [QID_W-1:0]     ruleQ     [NUM_RULES];
  logic                 ruleCen   [NUM_RULES];
  logic [CNT_W-1:0]     hitCnt    [NUM_RULES];

  // rule storage: a delete only drops the valid bit, a write loads everything
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) begin
        ruleValid[i] <= 1'b0;
        vTuple[i] <= '0;  mTuple[i] <= '0;
        vLip[i]   <= '0;  mLip[i]   <= '0;
        vFip[i]   <= '0;  mFip[i]   <= '0;
        vLport[i] <= '0;  mLport[i] <= '0;
        vFport[i] <= '0;  mFport[i] <= '0;
        ruleV6[i] <= 1'b0;
        ruleAct[i] <= '0;
        ruleDir[i] <= 1'b0;
        ruleQ[i]   <= '0;
        ruleCen[i] <= 1'b0;
      end
    end else if (strb.kill) begin
      ruleValid[cfgIdx] <= 1'b0;
    end else if (strb.load) begin
      ruleValid[cfgIdx] <= 1'b1;
      vTuple[cfgIdx] <= cfgValTuple;   mTuple[cfgIdx] <= cfgMaskTuple;
      vLip[cfgIdx]   <= cfgValLip;     mLip[cfgIdx]   <= cfgMaskLip;
      vFip[cfgIdx]   <= cfgValFip;     mFip[cfgIdx]   <= cfgMaskFip;
      vLport[cfgIdx] <= cfgValLport;   mLport[cfgIdx] <= cfgMaskLport;
      vFport[cfgIdx] <= cfgValFport;   mFport[cfgIdx] <= cfgMaskFport;
      ruleV6[cfgIdx]  <= cfgIsV6;
      ruleAct[cfgIdx] <= cfgAction;
      ruleDir[cfgIdx] <= cfgDirect;
      ruleQ[cfgIdx]   <= cfgQueue;
      ruleCen[cfgIdx] <= cfgCountEn;
    end
  end

  // one comparator bank per rule
  for (genvar g = 0; g < NUM_RULES; g++) begin : gRule
    logic fieldsOk;
    assign fieldsOk = ((lkTuple & mTuple[g]) == vTuple[g])
                    && ((lkLip   & mLip[g])   == vLip[g])
                    && ((lkFip   & mFip[g])   == vFip[g])
                    && ((lkLport & mLport[g]) == vLport[g])
                    && ((lkFport & mFport[g]) == vFport[g]);
    assign matchVec[g]   = ruleValid[g] & (ruleV6[g] == lkIsV6) & fieldsOk;
    assign countEnVec[g] = ruleCen[g];
  end

  // result register
  logic [1:0] winAct;
  assign winAct = (ruleAct[winIdx] == ACT_RSVD) ? ACT_PASS : ruleAct[winIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0; resHit <= 1'b0; resIdx <= '0;
      resAction <= '0;  resDirect <= 1'b0; resQueue <= '0;
    end else begin
      resValid <= strb.capture;
      if (strb.capture && anyHit) begin
        resHit    <= 1'b1;
        resIdx    <= winIdx;
        resAction <= winAct;
        resDirect <= ruleDir[winIdx];
        resQueue  <= ruleDir[winIdx] ? ruleQ[winIdx] : '0;
      end else begin
        resHit <= 1'b0; resIdx <= '0; resAction <= '0;
        resDirect <= 1'b0; resQueue <= '0;
      end
    end
  end

  // saturating hit counters, cleared on any configuration of their index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) hitCnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_RULES; i++) begin
        if ((strb.load || strb.kill) && cfgIdx == IDX_W'(i))
          hitCnt[i] <= '0;
        else if (strb.bump && winIdx == IDX_W'(i) && hitCnt[i] != CNT_MAX)
          hitCnt[i] <= hitCnt[i] + 1'b1;
      end
    end
  end

  assign cntValue = hitCnt[cntSel];
endmodule

// File: rtl/ingress_filter_table.sv
module ingress_filter_table import filt_pkg::*; #(
  parameter int NUM_RULES = 8,
  parameter int TUPLE_W   = 36,
  parameter int ADDR_W    = 128,
  parameter int PORT_W    = 16,
  parameter int QID_W     = 10,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = $clog2(NUM_RULES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrite,
  input  logic               cfgDelete,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic [TUPLE_W-1:0] cfgValTuple,
  input  logic [TUPLE_W-1:0] cfgMaskTuple,
  input  logic [ADDR_W-1:0]  cfgValLip,
  input  logic [ADDR_W-1:0]  cfgMaskLip,
  input  logic [ADDR_W-1:0]  cfgValFip,
  input  logic [ADDR_W-1:0]  cfgMaskFip,
  input  logic [PORT_W-1:0]  cfgValLport,
  input  logic [PORT_W-1:0]  cfgMaskLport,
  input  logic [PORT_W-1:0]  cfgValFport,
  input  logic [PORT_W-1:0]  cfgMaskFport,
  input  logic               cfgIsV6,
  input  logic [1:0]         cfgAction,
  input  logic               cfgDirect,
  input  logic [QID_W-1:0]   cfgQueue,
  input  logic               cfgCountEn,
  input  logic               lkValid,
  input  logic [TUPLE_W-1:0] lkTuple,
  input  logic [ADDR_W-1:0]  lkLip,
  input  logic [ADDR_W-1:0]  lkFip,
  input  logic [PORT_W-1:0]  lkLport,
  input  logic [PORT_W-1:0]  lkFport,
  input  logic               lkIsV6,
  output logic               resValid,
  output logic               resHit,
  output logic [IDX_W-1:0]   resIdx,
  output logic [1:0]         resAction,
  output logic               resDirect,
  output logic [QID_W-1:0]   resQueue,
  input  logic [IDX_W-1:0]   cntSel,
  output logic [CNT_W-1:0]   cntValue
);
  strobe_t              strb;
  logic [NUM_RULES-1:0] matchVec;
  logic [NUM_RULES-1:0] countEnVec;
  logic [IDX_W-1:0]     winIdx;
  logic                 anyHit;

  filt_ctrl #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) ctrl_i (
    .cfgWrite(cfgWrite), .cfgDelete(cfgDelete), .lkValid(lkValid),
    .matchVec(matchVec), .countEnVec(countEnVec),
    .strb(strb), .winIdx(winIdx), .anyHit(anyHit)
  );

  filt_datapath #(
    .NUM_RULES(NUM_RULES), .TUPLE_W(TUPLE_W), .ADDR_W(ADDR_W),
    .PORT_W(PORT_W), .QID_W(QID_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIdx(cfgIdx),
    .cfgValTuple(cfgValTuple), .cfgMaskTuple(cfgMaskTuple),
    .cfgValLip(cfgValLip), .cfgMaskLip(cfgMaskLip),
    .cfgValFip(cfgValFip), .cfgMaskFip(cfgMaskFip),
    .cfgValLport(cfgValLport), .cfgMaskLport(cfgMaskLport),
    .cfgValFport(cfgValFport), .cfgMaskFport(cfgMaskFport),
    .cfgIsV6(cfgIsV6), .cfgAction(cfgAction), .cfgDirect(cfgDirect),
    .cfgQueue(cfgQueue), .cfgCountEn(cfgCountEn),
    .lkTuple(lkTuple), .lkLip(lkLip), .lkFip(lkFip),
    .lkLport(lkLport), .lkFport(lkFport), .lkIsV6(lkIsV6),
    .winIdx(winIdx), .anyHit(anyHit),
    .matchVec(matchVec), .countEnVec(countEnVec),
    .resValid(resValid), .resHit(resHit), .resIdx(resIdx),
    .resAction(resAction), .resDirect(resDirect), .resQueue(resQueue),
    .cntSel(cntSel), .cntValue(cntValue)
  );
endmodule

// File: rtl/filt_table_chk.sv
module filt_table_chk #(
  parameter int IDX_W = 3,
  parameter int QID_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic             cfgWrite,
  input logic             cfgDelete,
  input logic [IDX_W-1:0] cntSel,
  input logic [CNT_W-1:0] cntValue,
  input logic             resValid,
  input logic             resHit,
  input logic [IDX_W-1:0] resIdx,
  input logic [1:0]       resAction,
  input logic             resDirect,
  input logic [QID_W-1:0] resQueue
);
  AST_RESULT_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(lkValid)); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (!resHit && resIdx == '0 && resAction == 2'd0 && !resDirect && resQueue == '0)); // R8

  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resHit) |-> (resIdx == '0 && resAction == 2'd0 && !resDirect && resQueue == '0)); // R5

  AST_NO_RSVD_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> resAction != 2'd3); // R6

  AST_HASH_NO_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resDirect) |-> resQueue == '0); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((!lkValid && !cfgWrite && !cfgDelete) ##1 $stable(cntSel)) |-> $stable(cntValue)); // R10
endmodule

bind ingress_filter_table filt_table_chk #(.IDX_W(IDX_W), .QID_W(QID_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .cfgWrite(cfgWrite),
  .cfgDelete(cfgDelete), .cntSel(cntSel), .cntValue(cntValue),
  .resValid(resValid), .resHit(resHit), .resIdx(resIdx),
  .resAction(resAction), .resDirect(resDirect), .resQueue(resQueue)
);

// File: tb/ingress_filter_table_tb_top.sv
module ingress_filter_table_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 8;
  localparam int IW  = 3;
  localparam int TW  = 36;
  localparam int AW  = 128;
  localparam int PW  = 16;
  localparam int QW  = 10;
  localparam int CW  = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 0, cfgDelete = 0;
  logic [IW-1:0] cfgIdx = '0;
  logic [TW-1:0] cfgValTuple = '0, cfgMaskTuple = '0;
  logic [AW-1:0] cfgValLip = '0, cfgMaskLip = '0, cfgValFip = '0, cfgMaskFip = '0;
  logic [PW-1:0] cfgValLport = '0, cfgMaskLport = '0, cfgValFport = '0, cfgMaskFport = '0;
  logic cfgIsV6 = 0;
  logic [1:0] cfgAction = '0;
  logic cfgDirect = 0;
  logic [QW-1:0] cfgQueue = '0;
  logic cfgCountEn = 0;
  logic lkValid = 0;
  logic [TW-1:0] lkTuple = '0;
  logic [AW-1:0] lkLip = '0, lkFip = '0;
  logic [PW-1:0] lkLport = '0, lkFport = '0;
  logic lkIsV6 = 0;
  logic resValid, resHit, resDirect;
  logic [IW-1:0] resIdx;
  logic [1:0] resAction;
  logic [QW-1:0] resQueue;
  logic [IW-1:0] cntSel = '0;
  logic [CW-1:0] cntValue;

  always #(CLK_PERIOD/2) clk = ~clk;

  ingress_filter_table #(.NUM_RULES(NR), .TUPLE_W(TW), .ADDR_W(AW), .PORT_W(PW),
                         .QID_W(QW), .CNT_W(CW)) dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // bench-side rule model
  logic [TW-1:0] mVT [NR], mMT [NR];
  logic [AW-1:0] mVL [NR], mML [NR], mVF [NR], mMF [NR];
  logic [PW-1:0] mVLP [NR], mMLP [NR], mVFP [NR], mMFP [NR];
  logic mV6 [NR], mDir [NR], mCen [NR], mValid [NR];
  logic [1:0] mAct [NR];
  logic [QW-1:0] mQ [NR];
  int expCnt [NR];

  localparam logic [AW-1:0] LIP6 = 128'h2001_0db8_0000_0000_0000_0000_0000_0042;
  localparam logic [AW-1:0] ALL_ONES = '1;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clearModel(input int i);
    mVT[i] = '0; mMT[i] = '0; mVL[i] = '0; mML[i] = '0; mVF[i] = '0; mMF[i] = '0;
    mVLP[i] = '0; mMLP[i] = '0; mVFP[i] = '0; mMFP[i] = '0;
    mV6[i] = 0; mDir[i] = 0; mCen[i] = 0; mValid[i] = 0; mAct[i] = '0; mQ[i] = '0;
    expCnt[i] = 0;
  endtask

  task automatic driveCfg(input int i);
    cfgIdx = IW'(i);
    cfgValTuple = mVT[i]; cfgMaskTuple = mMT[i];
    cfgValLip = mVL[i]; cfgMaskLip = mML[i]; cfgValFip = mVF[i]; cfgMaskFip = mMF[i];
    cfgValLport = mVLP[i]; cfgMaskLport = mMLP[i]; cfgValFport = mVFP[i]; cfgMaskFport = mMFP[i];
    cfgIsV6 = mV6[i]; cfgAction = mAct[i]; cfgDirect = mDir[i]; cfgQueue = mQ[i]; cfgCountEn = mCen[i];
  endtask

  task automatic pushRule(input int i, input bit alsoDelete);
    @(negedge clk);
    driveCfg(i);
    cfgWrite = 1; cfgDelete = alsoDelete;
    @(negedge clk);
    cfgWrite = 0; cfgDelete = 0;
    mValid[i] = !alsoDelete;
    expCnt[i] = 0;
  endtask

  task automatic killRule(input int i);
    @(negedge clk);
    cfgIdx = IW'(i); cfgDelete = 1;
    @(negedge clk);
    cfgDelete = 0;
    mValid[i] = 0;
    expCnt[i] = 0;
  endtask

  function automatic int refWin(input logic [TW-1:0] t, input logic [AW-1:0] l, input logic [AW-1:0] f,
                                input logic [PW-1:0] lp, input logic [PW-1:0] fp, input logic v6);
    for (int i = 0; i < NR; i++) begin
      if (mValid[i] && mV6[i] == v6 && (t & mMT[i]) == mVT[i] && (l & mML[i]) == mVL[i] &&
          (f & mMF[i]) == mVF[i] && (lp & mMLP[i]) == mVLP[i] && (fp & mMFP[i]) == mVFP[i])
        return i;
    end
    return -1;
  endfunction

  // present one key, compare every result field against the model
  task automatic lookupCheck(input logic [TW-1:0] t, input logic [AW-1:0] l, input logic [AW-1:0] f,
                             input logic [PW-1:0] lp, input logic [PW-1:0] fp, input logic v6,
                             output int win);
    int w;
    w = refWin(t, l, f, lp, fp, v6);
    @(negedge clk);
    lkValid = 1; lkTuple = t; lkLip = l; lkFip = f; lkLport = lp; lkFport = fp; lkIsV6 = v6;
    @(negedge clk);
    lkValid = 0;
    chk("R8", "resValid", 64'(resValid), 64'd1);
    if (w < 0) begin
      chk("R5", "miss hit", 64'(resHit), 64'd0);
      chk("R5", "miss idx", 64'(resIdx), 64'd0);
      chk("R5", "miss action", 64'(resAction), 64'd0);
      chk("R5", "miss queue", 64'(resQueue), 64'd0);
    end else begin
      chk("R1", "hit", 64'(resHit), 64'd1);
      chk("R4", "winner idx", 64'(resIdx), 64'(w));
      chk("R6", "action", 64'(resAction), 64'((mAct[w] == 2'd3) ? 2'd0 : mAct[w]));
      chk("R7", "direct", 64'(resDirect), 64'(mDir[w]));
      chk("R7", "queue", 64'(resQueue), 64'(mDir[w] ? mQ[w] : '0));
      if (mCen[w] && expCnt[w] < CMAX) expCnt[w]++;
    end
    win = w;
  endtask

  task automatic checkCounters(input string req);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      cntSel = IW'(i);
      #1;
      chk(req, $sformatf("counter %0d", i), 64'(cntValue), 64'(expCnt[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    logic [AW-1:0] fipSet [4];
    fipSet[0] = 128'h0A01_024D;                                   // inside 10.1.2.0/24
    fipSet[1] = 128'h0A01_0305;                                   // outside
    fipSet[2] = 128'hFFFF_0000_0000_0000_0000_0000_0A01_02FE;     // upper bytes ignored by mask
    fipSet[3] = '0;
    for (int i = 0; i < NR; i++) clearModel(i);

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11: empty state after reset
    chk("R8", "idle resValid", 64'(resValid), 64'd0);
    chk("R8", "idle resHit", 64'(resHit), 64'd0);
    checkCounters("R11");
    lookupCheck(36'h1, '0, '0, '0, '0, 1'b0, w);     // empty table misses (R5)

    // rule 1: IPv4 foreign subnet, switch, direct queue 7, no counting
    mVF[1] = 128'h0A01_0200; mMF[1] = 128'hFFFF_FF00; mAct[1] = 2'd2; mDir[1] = 1; mQ[1] = 10'd7;
    pushRule(1, 0);
    // rule 2: IPv6 exact local address and local port 443, pass, queue 0x3FF, counted
    mVL[2] = LIP6; mML[2] = ALL_ONES; mVLP[2] = 16'd443; mMLP[2] = 16'hFFFF; mV6[2] = 1;
    mDir[2] = 1; mQ[2] = 10'h3FF; mCen[2] = 1;
    pushRule(2, 0);
    // rule 5: tuple low nibble A, drop, direct queue 0x155, counted
    mVT[5] = 36'hA; mMT[5] = 36'hF; mAct[5] = 2'd1; mDir[5] = 1; mQ[5] = 10'h155; mCen[5] = 1;
    pushRule(5, 0);
    // rule 6: full wildcard IPv4, reserved action, hash steering with a nonzero queue, counted
    mAct[6] = 2'd3; mQ[6] = 10'h2AA; mCen[6] = 1;
    pushRule(6, 0);

    // sweep: R1 R4 R6 R7 across overlapping rules
    for (int t = 0; t < 16; t++)
      for (int v = 0; v < 2; v++)
        for (int fc = 0; fc < 4; fc++)
          for (int pc = 0; pc < 2; pc++)
            lookupCheck(36'h9_1234_5670 | 36'(t), LIP6, fipSet[fc],
                        pc == 0 ? 16'd443 : 16'd80, 16'h1234, v[0], w);
    checkCounters("R10");
    cntSel = 3'd6; #1;
    chk("R10", "saturated counter", 64'(cntValue), 64'(CMAX));

    // R3: same address and port as rule 2 but IPv4 key does not hit rule 2
    lookupCheck(36'h0, LIP6, '0, 16'd443, 16'd0, 1'b0, w);
    chk("R3", "family mismatch winner", 64'(resIdx), 64'd6);
    // R2: arbitrary contents hit the all-wildcard rule
    lookupCheck(36'hF_FFFF_FFF3, ALL_ONES, ALL_ONES, 16'hFFFF, 16'hFFFF, 1'b0, w);
    chk("R2", "wildcard winner", 64'(resIdx), 64'd6);
    // R4: key hitting rules 1, 5, 6 picks 1
    lookupCheck(36'hA, '0, fipSet[0], '0, '0, 1'b0, w);
    chk("R4", "lowest index", 64'(resIdx), 64'd1);

    // R9: delete the catch-all, then a former catch-all key misses
    killRule(6);
    lookupCheck(36'h3, '0, '0, '0, '0, 1'b0, w);
    chk("R9", "deleted rule miss", 64'(resHit), 64'd0);
    // R9: write and delete together on rule 5 leaves it invalid
    pushRule(5, 1);
    lookupCheck(36'hA, '0, '0, '0, '0, 1'b0, w);
    chk("R9", "delete beats write", 64'(resHit), 64'd0);

    // R11: rewriting rule 2 clears its counter
    lookupCheck(36'h0, LIP6, '0, 16'd443, '0, 1'b1, w);
    @(negedge clk); cntSel = 3'd2; #1;
    chk("R10", "counter before rewrite", 64'(cntValue), 64'(expCnt[2]));
    pushRule(2, 0);
    checkCounters("R11");

    @(negedge clk);
    chk("R8", "final idle resValid", 64'(resValid), 64'd0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule